// File: doc/BRIEF.md
# Byte Store Controller with Timed Write Unlock

This block sits on a small processor register bus and fronts an internal array of nonvolatile bytes. Software reaches it through four byte-wide registers: a control register, a data register, and an address split into a low byte and a high byte. Reading a stored byte is a single strobe. Writing one needs a two-step unlock: software first arms a master enable, then sets the write enable within a short window. Any later attempt is dropped, so a runaway code path that only reaches the second step cannot change the store.

A programming operation runs for a parameterised number of cycles that depends on the selected mode: erase only, write only (bits can only be cleared), or erase followed by write. While it runs, the write-enable bit reads back as 1 and acts as the busy flag. A ready interrupt is raised whenever it is enabled and no operation is in progress. A separate input from the flash self-programming logic blocks new operations while it is high. The array is a behavioural model whose cells all read 0xFF after reset.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the control, data and both address registers read 0x00, `irq` is 0, and every stored byte reads 0xFF.
- R2: Register offsets are control 0x3F, data 0x40, address low 0x41 and address high 0x42. The high register keeps ADDR_W-8 bits and its other bits read 0. Other offsets read 0. Control bits are: bit0 read request (reads 0), bit1 write enable/busy, bit2 master write enable, bit3 ready-interrupt enable, bits5:4 mode, bits7:6 always 0.
- R3: A control write with bit2=1 and bit1=0 arms the master enable. Bit2 then reads 1 for the four cycles after that write and reads 0 from the fifth cycle on.
- R4: A control write with bit1=1 starts programming only while the master enable is armed, i.e. in one of the four cycles after the arming write. Later attempts, attempts with no arming, and a single write that sets bit2 and bit1 together start nothing and leave the byte unchanged.
- R5: While `spm_busy` is 1, a write-enable attempt starts nothing.
- R6: Bit1 reads 1 for exactly the programming time of the mode carried in the starting write: mode 01 takes ERASE_CYC cycles, mode 10 takes WRITE_CYC cycles, and modes 00 and 11 take ERASE_CYC+WRITE_CYC cycles.
- R7: When programming completes, the addressed byte holds the data value for modes 00 and 11, holds 0xFF for mode 01, and holds the old value ANDed with the data value for mode 10.
- R8: The target address and data are captured when programming starts. Writes to the address or data registers during the operation do not change which byte is programmed or its value.
- R9: A control write with bit0=1 while idle loads the data register with the byte at the current address on the next cycle.
- R10: While busy, a control write updates only bit3. Read requests, arming, write attempts and mode changes made during that time have no effect.
- R11: `irq` is 1 exactly when bit3 is 1 and no operation is busy.
- R12: Addresses of 256 and above are reached through the high byte and do not alias onto the low 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for the register at `bus_addr`; combinational |
| spm_busy | input | 1 | Flash self-programming in progress; blocks new write starts |
| irq | output | 1 | Ready interrupt |

## Verification
The assertions assume a register bus that presents at most one write per cycle, on one offset, so that a read request and a write start never come in the same control write. They also assume that `spm_busy` changes only between clock edges. The bench drives every bus write half a cycle before the sampling edge and toggles `spm_busy` only while the bus is quiet. It never combines read-request and write-enable bits in one control write, so the sequencer always captures a settled data register.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  localparam logic [7:0] OFS_CTRL = 8'h3F;
  localparam logic [7:0] OFS_DATA = 8'h40;
  localparam logic [7:0] OFS_ALO  = 8'h41;
  localparam logic [7:0] OFS_AHI  = 8'h42;

  localparam int B_RD  = 0;
  localparam int B_WE  = 1;
  localparam int B_MWE = 2;
  localparam int B_RIE = 3;
  localparam int B_M0  = 4;

  typedef enum logic [1:0] {
    PM_ERASE_WRITE = 2'b00,
    PM_ERASE       = 2'b01,
    PM_WRITE       = 2'b10,
    PM_ALT         = 2'b11
  } pmode_e;

  function automatic int unsigned prog_len(pmode_e m, int unsigned e, int unsigned w);
    case (m)
      PM_ERASE: return e;
      PM_WRITE: return w;
      default:  return e + w;
    endcase
  endfunction

endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic consume,
  output logic armed
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (consume)
      cnt_d = '0;
    else if (arm)
      cnt_d = CW'(WIN);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign armed = (cnt_q != '0);
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int ERASE_CYC = 20,
  parameter int WRITE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pmode_e            mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              busy,
  output logic              commit,
  output pmode_e            c_mode,
  output logic [ADDR_W-1:0] c_addr,
  output logic [7:0]        c_data
);
  localparam int CNT_W = $clog2(ERASE_CYC + WRITE_CYC + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  pmode_e            mode_q, mode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic              last;

  assign last = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    mode_d = mode_q;
    addr_d = addr_q;
    data_d = data_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(prog_len(mode, ERASE_CYC, WRITE_CYC));
      mode_d = mode;
      addr_d = addr;
      data_d = data;
    end else if (busy_q) begin
      if (last)
        busy_d = 1'b0;
      else
        cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      mode_q <= PM_ERASE_WRITE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      mode_q <= mode_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy   = busy_q;
  assign commit = last;
  assign c_mode = mode_q;
  assign c_addr = addr_q;
  assign c_data = data_q;
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  pmode_e            c_mode,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [7:0]        c_data,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] merged;

  always_comb begin
    case (c_mode)
      PM_ERASE: merged = 8'hFF;
      PM_WRITE: merged = mem[c_addr] & c_data;
      default:  merged = c_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= 8'hFF;
    end else if (commit) begin
      mem[c_addr] <= merged;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int ERASE_CYC  = 20,
  parameter int WRITE_CYC  = 12,
  parameter int UNLOCK_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       spm_busy,
  output logic       irq
);
  localparam int HI_W = ADDR_W - 8;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // bus decode
  logic wr_ctrl, wr_data, wr_alo, wr_ahi;
  assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
  assign wr_data = bus_we && (bus_addr == OFS_DATA);
  assign wr_alo  = bus_we && (bus_addr == OFS_ALO);
  assign wr_ahi  = bus_we && (bus_addr == OFS_AHI);

  // state
  logic              rie_q, rie_d;
  pmode_e            mode_q, mode_d;
  logic [7:0]        data_q, data_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              busy, armed, commit;
  logic              arm, start, rd_req;
  logic              data_en, addr_en;
  pmode_e            c_mode;
  logic [ADDR_W-1:0] c_addr;
  logic [7:0]        c_data, arr_rdata;

  always_comb begin
    rie_d  = rie_q;
    mode_d = mode_q;
    arm    = 1'b0;
    start  = 1'b0;
    rd_req = 1'b0;
    if (wr_ctrl) begin
      rie_d = bus_wdata[B_RIE];
      if (!busy) begin
        mode_d = pmode_e'(bus_wdata[B_M0+1:B_M0]);
        arm    = bus_wdata[B_MWE] && !bus_wdata[B_WE];
        start  = bus_wdata[B_WE] && armed && !spm_busy;
        rd_req = bus_wdata[B_RD];
      end
    end
  end

  always_comb begin
    data_en = wr_data || rd_req;
    data_d  = rd_req ? arr_rdata : bus_wdata;
    addr_en = wr_alo || wr_ahi;
    addr_d  = addr_q;
    if (wr_alo) addr_d[7:0]        = bus_wdata;
    if (wr_ahi) addr_d[ADDR_W-1:8] = bus_wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rie_q  <= 1'b0;
      mode_q <= PM_ERASE_WRITE;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      rie_q  <= rie_d;
      mode_q <= mode_d;
      if (data_en) data_q <= data_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  nvm_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .arm     (arm),
    .consume (start),
    .armed   (armed)
  );

  nvm_seq #(
    .ADDR_W    (ADDR_W),
    .ERASE_CYC (ERASE_CYC),
    .WRITE_CYC (WRITE_CYC)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .mode   (pmode_e'(bus_wdata[B_M0+1:B_M0])),
    .addr   (addr_q),
    .data   (data_q),
    .busy   (busy),
    .commit (commit),
    .c_mode (c_mode),
    .c_addr (c_addr),
    .c_data (c_data)
  );

  nvm_array #(.ADDR_W(ADDR_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .commit (commit),
    .c_mode (c_mode),
    .c_addr (c_addr),
    .c_data (c_data),
    .raddr  (addr_q),
    .rdata  (arr_rdata)
  );

  // read-back
  logic [7:0] hi_ext;
  always_comb begin
    hi_ext = '0;
    hi_ext[HI_W-1:0] = addr_q[ADDR_W-1:8];
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {2'b00, mode_q, rie_q, armed, busy, 1'b0};
      OFS_DATA: bus_rdata = data_q;
      OFS_ALO:  bus_rdata = addr_q[7:0];
      OFS_AHI:  bus_rdata = hi_ext;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign irq = rie_q && !busy;
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk
  import nvm_pkg::*;
#(
  parameter int ERASE_CYC = 20,
  parameter int WRITE_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       spm_busy,
  input logic       irq,
  input logic       busy,
  input logic       armed,
  input logic [7:0] data_q,
  input pmode_e     seq_mode
);
  logic        busy_q;
  int unsigned run_len;
  int unsigned want_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      run_len  <= 0;
      want_len <= 0;
    end else begin
      busy_q  <= busy;
      run_len <= busy ? run_len + 1 : 0;
      if (busy && !busy_q)
        want_len <= prog_len(seq_mode, ERASE_CYC, WRITE_CYC);
    end
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> (bus_rdata[7:6] == 2'b00 && bus_rdata[B_RD] == 1'b0));

  // R4 and R5: a start always follows an armed window with the interlock low
  p_start_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(armed) && !$past(spm_busy)));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == want_len));

  p_read_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_addr == OFS_CTRL && bus_wdata[B_RD]) |=> $stable(data_q));

  p_irq_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && bus_addr == OFS_CTRL) |-> (bus_rdata[B_RIE] && !bus_rdata[B_WE]));

  p_irq_quiet_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(
  .ERASE_CYC (ERASE_CYC),
  .WRITE_CYC (WRITE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .spm_busy  (spm_busy),
  .irq       (irq),
  .busy      (busy),
  .armed     (armed),
  .data_q    (data_q),
  .seq_mode  (u_seq.c_mode)
);

// File: tb/nvm_ctrl_bench.sv
module nvm_ctrl_bench;
  localparam int E_CYC = 20;
  localparam int W_CYC = 12;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_we;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       spm_busy;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit rie   = 1'b0;

  always #4 clk = ~clk;

  nvm_ctrl #(.ADDR_W(9), .ERASE_CYC(E_CYC), .WRITE_CYC(W_CYC), .UNLOCK_WIN(4)) u_nvm_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .spm_busy  (spm_busy),
    .irq       (irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_mem [DEPTH];
  int m_data, m_addr, m_mode, m_win, m_left, p_addr, p_data, p_mode;
  bit m_rie, m_busy;

  function automatic int plen(int m);
    if (m == 1) return E_CYC;
    if (m == 2) return W_CYC;
    return E_CYC + W_CYC;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      8'h3F:   return (m_mode << 4) | (int'(m_rie) << 3) | (int'(m_win > 0) << 2) | (int'(m_busy) << 1);
      8'h40:   return m_data;
      8'h41:   return m_addr & 8'hFF;
      8'h42:   return m_addr >> 8;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit ob, oarm, st, ar;
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
      m_data = 0; m_addr = 0; m_mode = 0; m_win = 0; m_left = 0;
      m_rie = 0; m_busy = 0; p_addr = 0; p_data = 0; p_mode = 0;
    end else begin
      ob = m_busy; oarm = (m_win > 0); st = 0; ar = 0;
      if (m_busy) begin
        if (m_left == 1) begin
          if (p_mode == 1)      m_mem[p_addr] = 8'hFF;
          else if (p_mode == 2) m_mem[p_addr] = m_mem[p_addr] & p_data;
          else                  m_mem[p_addr] = p_data;
          m_busy = 0;
        end else m_left--;
      end
      if (bus_we) begin
        case (bus_addr)
          8'h3F: begin
            m_rie = bus_wdata[3];
            if (!ob) begin
              m_mode = int'(bus_wdata[5:4]);
              st = bus_wdata[1] && oarm && !spm_busy;
              ar = bus_wdata[2] && !bus_wdata[1];
              if (st) begin
                p_addr = m_addr; p_data = m_data; p_mode = m_mode;
              end
              if (bus_wdata[0]) m_data = m_mem[m_addr];
            end
          end
          8'h40: m_data = bus_wdata;
          8'h41: m_addr = (m_addr & 32'h100) | bus_wdata;
          8'h42: m_addr = (m_addr & 32'hFF) | (int'(bus_wdata[0]) << 8);
          default: ;
        endcase
      end
      if (st) begin
        m_busy = 1; m_left = plen(p_mode); m_win = 0;
      end else if (ar) m_win = 4;
      else if (m_win > 0) m_win--;
    end
  end

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1) begin
      chk(irq === (m_rie && !m_busy), "R11 irq vs model", irq, int'(m_rie && !m_busy));
      chk(bus_rdata === 8'(exp_rd(bus_addr)), "R2 rdata vs model", bus_rdata, exp_rd(bus_addr));
    end
  end

  // ---------------- stimulus tasks (called at a falling edge) ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_loc(input int a, input logic [7:0] d);
    wr(8'h41, 8'(a));
    wr(8'h42, 8'(a >> 8));
    wr(8'h40, d);
  endtask

  task automatic arm(input logic [1:0] m);
    wr(8'h3F, {2'b00, m, rie, 3'b100});
  endtask

  task automatic go(input logic [1:0] m);
    wr(8'h3F, {2'b00, m, rie, 3'b010});
  endtask

  task automatic prog(input logic [1:0] m, input int a, input logic [7:0] d);
    set_loc(a, d);
    arm(m);
    go(m);
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] v;
    n = 0;
    rd(8'h3F, v);
    while (v[1]) begin
      n++;
      @(negedge clk);
      rd(8'h3F, v);
    end
  endtask

  task automatic read_loc(input int a, output logic [7:0] v);
    wr(8'h41, 8'(a));
    wr(8'h42, 8'(a >> 8));
    wr(8'h3F, {4'b0000, rie, 3'b001});
    rd(8'h40, v);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0] v;
    int n;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; spm_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(8'h3F, v); chk(v == 8'h00, "R1 ctrl after reset", v, 0);
    rd(8'h40, v); chk(v == 8'h00, "R1 data after reset", v, 0);
    rd(8'h42, v); chk(v == 8'h00, "R1 addr high after reset", v, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    read_loc(0, v); chk(v == 8'hFF, "R1 erased byte", v, 8'hFF);

    // R11 enable ready interrupt
    rie = 1'b1;
    wr(8'h3F, 8'h08);
    chk(irq == 1'b1, "R11 irq when idle and enabled", irq, 1);

    // R2 address register widths, unmapped offset
    wr(8'h42, 8'hFF); rd(8'h42, v); chk(v == 8'h01, "R2 high byte width", v, 1);
    wr(8'h41, 8'hA5); rd(8'h41, v); chk(v == 8'hA5, "R2 low byte", v, 8'hA5);
    rd(8'h43, v); chk(v == 8'h00, "R2 unmapped offset", v, 0);

    // R3, R4, R6, R7, R9 mode 00 with back-to-back unlock
    set_loc(5, 8'h5A);
    arm(2'b00);
    rd(8'h3F, v); chk(v[2] == 1'b1, "R3 master enable armed", v, 8'h0C);
    go(2'b00);
    rd(8'h3F, v); chk(v == 8'h0A, "R6 busy after start", v, 8'h0A);
    chk(irq == 1'b0, "R11 irq low while busy", irq, 0);
    wait_idle(n); chk(n == E_CYC + W_CYC, "R6 mode 00 duration", n, E_CYC + W_CYC);
    chk(irq == 1'b1, "R11 irq back when done", irq, 1);
    read_loc(5, v); chk(v == 8'h5A, "R7 R9 erase-write result", v, 8'h5A);

    // R10 mode 11 with writes while busy
    prog(2'b11, 6, 8'hC3);
    wr(8'h3F, 8'h05);
    rd(8'h3F, v); chk(v == 8'h32, "R10 ctrl ignores all but bit3", v, 8'h32);
    chk(irq == 1'b0, "R11 irq stays low", irq, 0);
    rd(8'h40, v); chk(v == 8'hC3, "R10 read ignored while busy", v, 8'hC3);
    wr(8'h3F, 8'h08);
    wait_idle(n);
    read_loc(6, v); chk(v == 8'hC3, "R7 mode 11 like 00", v, 8'hC3);

    // R6, R7 erase only
    prog(2'b01, 5, 8'h00);
    wait_idle(n); chk(n == E_CYC, "R6 mode 01 duration", n, E_CYC);
    read_loc(5, v); chk(v == 8'hFF, "R7 erase only", v, 8'hFF);

    // R6, R7 write only clears bits
    prog(2'b10, 5, 8'h3C);
    wait_idle(n); chk(n == W_CYC, "R6 mode 10 duration", n, W_CYC);
    read_loc(5, v); chk(v == 8'h3C, "R7 write only on erased", v, 8'h3C);
    prog(2'b10, 5, 8'hF0);
    wait_idle(n);
    read_loc(5, v); chk(v == 8'h30, "R7 write only ANDs", v, 8'h30);

    // R3, R4 last cycle of the window still accepted
    set_loc(7, 8'h81);
    arm(2'b00); idle(3);
    rd(8'h3F, v); chk(v[2] == 1'b1, "R3 armed in fourth cycle", v[2], 1);
    go(2'b00);
    rd(8'h3F, v); chk(v[1] == 1'b1, "R4 start at window end", v[1], 1);
    wait_idle(n);
    read_loc(7, v); chk(v == 8'h81, "R4 late-window write", v, 8'h81);

    // R3, R4 window expired
    set_loc(8, 8'h42);
    arm(2'b00); idle(4);
    rd(8'h3F, v); chk(v[2] == 1'b0, "R3 window closed", v[2], 0);
    go(2'b00);
    rd(8'h3F, v); chk(v[1] == 1'b0, "R4 no start after window", v[1], 0);
    read_loc(8, v); chk(v == 8'hFF, "R4 byte unchanged", v, 8'hFF);

    // R4 both bits in one write
    set_loc(8, 8'h42);
    wr(8'h3F, 8'h0E);
    rd(8'h3F, v); chk(v == 8'h08, "R4 combined write starts nothing", v, 8'h08);

    // R5 interlock
    spm_busy = 1'b1;
    arm(2'b00); go(2'b00);
    rd(8'h3F, v); chk(v[1] == 1'b0, "R5 blocked by interlock", v[1], 0);
    spm_busy = 1'b0;
    read_loc(8, v); chk(v == 8'hFF, "R5 byte unchanged", v, 8'hFF);

    // R8, R12 capture at start, high address
    prog(2'b00, 32'h1F3, 8'h77);
    wr(8'h41, 8'h00); wr(8'h40, 8'h11); wr(8'h42, 8'h00);
    wait_idle(n);
    read_loc(32'h1F3, v); chk(v == 8'h77, "R8 R12 captured target", v, 8'h77);
    read_loc(32'h0F3, v); chk(v == 8'hFF, "R12 no alias below 256", v, 8'hFF);
    read_loc(0, v);       chk(v == 8'hFF, "R8 late address ignored", v, 8'hFF);

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule